// File: doc/BRIEF.md
# Dual-Harmonic Lock-In Demodulator

This block takes a stream of signed photodetector samples, one per clock, and recovers how strongly a low-frequency modulation tone appears in them. It generates that tone itself from a phase accumulator and puts out the tone's sine as the modulation drive. It multiplies each incoming sample by reference sinusoids at the tone frequency f and at 2f. Each harmonic has its own programmable phase offset and yields an in-phase and a quadrature product.

Each of the four products passes through a three-stage decimating CIC low-pass filter. The four filters share one power-of-two decimation rate. Their outputs are normalised by the filter gain and update together under a single valid strobe. A feedback loop downstream reads the four channels and steers a modulator's bias voltages. That loop is not part of this block.

Top module: `dual_harmonic_lockin`

## Requirements
- R1: `mod_out` equals round(511·sin(2π·a/64)), where a is the top 6 bits of the phase accumulator. The accumulator is zero while `enable` is low and advances by `freq_word` (modulo 2^PW) on every enabled clock edge. So in the cycle after enabled edge n, `mod_out` reflects the phase (n+1)·`freq_word`.
- R2: The sample taken on enabled edge n (n counted from 0 after enable) is multiplied by two references. The in-phase (`i_f`) reference is the sine at phase θ = n·`freq_word` + `phase_f`. The quadrature (`q_f`) reference is the sine at θ + 2^(PW-2), i.e. a quarter cycle later. Every sine value is looked up from the top 6 phase bits with the rounding of R1.
- R3: The 2f products use the phase 2·n·`freq_word` + `phase_2f` for `i_2f`, and that phase plus a quarter cycle for `q_2f`. All phase arithmetic is modulo 2^PW.
- R4: With R = 2^k, each output equals floor(Σ h[j]·p[m−j] / R³). Here p is that channel's product, m is the index of the latest sample, and h is the length-(3R−2) impulse response of three cascaded R-tap box sums. Products from before the enable edge count as zero.
- R5: `out_valid` is high for exactly the one cycle after enabled edges R−1, 2R−1, 3R−1, … (every cycle when R = 1). All four outputs change only together with it and hold their values in between.
- R6: The rate code k is read from `rate_log2`. A code above MAXLOG (6 by default) acts as MAXLOG.
- R7: A clock edge with `enable` low clears the accumulator, the filter state and the four outputs, and leaves `out_valid` low. This holds even on an edge that would otherwise end a decimation block. The next enable starts from zero history.
- R8: After reset, `out_valid`, `mod_out` and all four outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run; low clears all state |
| sample_in | input | DW | Signed detector sample |
| freq_word | input | PW | Phase increment per clock |
| phase_f | input | PW | Phase offset of the f references |
| phase_2f | input | PW | Phase offset of the 2f references |
| rate_log2 | input | RLW | Decimation rate exponent k (R = 2^k) |
| mod_out | output | 10 | Signed modulation sine |
| i_f | output | DW+10 | Filtered in-phase product at f |
| q_f | output | DW+10 | Filtered quadrature product at f |
| i_2f | output | DW+10 | Filtered in-phase product at 2f |
| q_2f | output | DW+10 | Filtered quadrature product at 2f |
| out_valid | output | 1 | One-cycle strobe when outputs update |

## Verification
The integrators absorb a new product on every edge, and on the last edge of each block the comb section also emits a result. The two functions that can land on the same edge are a decimation output and a disable. Every run therefore ends with `enable` dropped exactly on an edge that closes a block. The bench then expects `out_valid` to stay low, the outputs and `mod_out` to read zero, and the next run to match a model built from zero history. Within each run, every strobe is compared against an arithmetic convolution of the bench's own products. This covers rates 1, 2, 4, 8 and 64, a clamped rate code, and phases that wrap.

// File: rtl/dual_harmonic_lockin.sv
module dual_harmonic_lockin #(
  parameter int DW     = 12,
  parameter int PW     = 16,
  parameter int MAXLOG = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic signed [DW-1:0]        sample_in,
  input  logic [PW-1:0]               freq_word,
  input  logic [PW-1:0]               phase_f,
  input  logic [PW-1:0]               phase_2f,
  input  logic [$clog2(MAXLOG+1)-1:0] rate_log2,
  output logic signed [9:0]           mod_out,
  output logic signed [DW+9:0]        i_f,
  output logic signed [DW+9:0]        q_f,
  output logic signed [DW+9:0]        i_2f,
  output logic signed [DW+9:0]        q_2f,
  output logic                        out_valid
);
  localparam int SW   = 10;
  localparam int LUTW = 6;
  localparam int OW   = DW + SW;
  localparam int AW   = OW + 3 * MAXLOG;
  localparam int RLW  = $clog2(MAXLOG + 1);
  localparam int SHW  = $clog2(3 * MAXLOG + 1);
  localparam logic [PW-1:0] QTR = PW'(1) << (PW - 2);

  function automatic logic [SW-1:0] quarter_mag(input logic [4:0] j);
    case (j)
      5'd0:  quarter_mag = 10'd0;
      5'd1:  quarter_mag = 10'd50;
      5'd2:  quarter_mag = 10'd100;
      5'd3:  quarter_mag = 10'd148;
      5'd4:  quarter_mag = 10'd196;
      5'd5:  quarter_mag = 10'd241;
      5'd6:  quarter_mag = 10'd284;
      5'd7:  quarter_mag = 10'd324;
      5'd8:  quarter_mag = 10'd361;
      5'd9:  quarter_mag = 10'd395;
      5'd10: quarter_mag = 10'd425;
      5'd11: quarter_mag = 10'd451;
      5'd12: quarter_mag = 10'd472;
      5'd13: quarter_mag = 10'd489;
      5'd14: quarter_mag = 10'd501;
      5'd15: quarter_mag = 10'd509;
      default: quarter_mag = 10'd511;
    endcase
  endfunction

  function automatic logic signed [SW-1:0] sine_of(input logic [LUTW-1:0] a);
    logic [4:0]    j;
    logic [SW-1:0] m;
    j = a[4] ? (5'd16 - {1'b0, a[3:0]}) : {1'b0, a[3:0]};
    m = quarter_mag(j);
    sine_of = a[5] ? -$signed(m) : $signed(m);
  endfunction

  logic [PW-1:0]     acc;
  logic [MAXLOG-1:0] cnt;
  logic [RLW-1:0]    keff;
  logic [SHW-1:0]    shamt;
  logic              last;
  logic [LUTW-1:0]   lut_a [4];

  assign keff  = (rate_log2 > RLW'(MAXLOG)) ? RLW'(MAXLOG) : rate_log2;
  assign shamt = SHW'(3 * keff);
  assign last  = (cnt == MAXLOG'((32'd1 << keff) - 32'd1));

  assign lut_a[0] = LUTW'((acc + phase_f) >> (PW - LUTW));
  assign lut_a[1] = LUTW'((acc + phase_f + QTR) >> (PW - LUTW));
  assign lut_a[2] = LUTW'(({acc[PW-2:0], 1'b0} + phase_2f) >> (PW - LUTW));
  assign lut_a[3] = LUTW'(({acc[PW-2:0], 1'b0} + phase_2f + QTR) >> (PW - LUTW));

  assign mod_out = sine_of(LUTW'(acc >> (PW - LUTW)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else if (!enable) begin
      acc       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      acc       <= acc + freq_word;
      cnt       <= last ? '0 : cnt + 1'b1;
      out_valid <= last;
    end
  end

  for (genvar c = 0; c < 4; c++) begin : g_ch
    logic signed [SW-1:0] rs;
    logic signed [OW-1:0] prod;
    logic [AW-1:0] s1, s2, s3, z1, z2, z3;
    logic [AW-1:0] n1, n2, n3, c1, c2, c3;
    logic signed [OW-1:0] yv, y_q;

    assign rs   = sine_of(lut_a[c]);
    assign prod = sample_in * rs;
    assign n1   = s1 + {{(AW-OW){prod[OW-1]}}, prod};
    assign n2   = s2 + n1;
    assign n3   = s3 + n2;
    assign c1   = n3 - z1;
    assign c2   = c1 - z2;
    assign c3   = c2 - z3;
    assign yv   = OW'($signed(c3) >>> shamt);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        {s1, s2, s3, z1, z2, z3} <= '0;
        y_q <= '0;
      end else if (!enable) begin
        {s1, s2, s3, z1, z2, z3} <= '0;
        y_q <= '0;
      end else begin
        s1 <= n1;
        s2 <= n2;
        s3 <= n3;
        if (last) begin
          z1  <= n3;
          z2  <= c1;
          z3  <= c2;
          y_q <= yv;
        end
      end
    end
  end

  assign i_f  = g_ch[0].y_q;
  assign q_f  = g_ch[1].y_q;
  assign i_2f = g_ch[2].y_q;
  assign q_2f = g_ch[3].y_q;
endmodule

// File: rtl/dual_harmonic_lockin_chk.sv
module dual_harmonic_lockin_chk #(
  parameter int DW     = 12,
  parameter int PW     = 16,
  parameter int MAXLOG = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        enable,
  input logic [$clog2(MAXLOG+1)-1:0] rate_log2,
  input logic signed [9:0]           mod_out,
  input logic signed [DW+9:0]        i_f,
  input logic signed [DW+9:0]        q_f,
  input logic signed [DW+9:0]        i_2f,
  input logic signed [DW+9:0]        q_2f,
  input logic                        out_valid
);
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && out_valid && rate_log2 != '0) |=> !out_valid);

  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !out_valid) |->
      ($stable(i_f) && $stable(q_f) && $stable(i_2f) && $stable(q_2f)));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid && i_f == '0 && q_f == '0 && i_2f == '0 && q_2f == '0));

  p_valid_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(enable));

  p_mod_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (mod_out == '0));
endmodule

bind dual_harmonic_lockin dual_harmonic_lockin_chk #(.DW(DW), .PW(PW), .MAXLOG(MAXLOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rate_log2(rate_log2),
  .mod_out(mod_out), .i_f(i_f), .q_f(q_f), .i_2f(i_2f), .q_2f(q_2f),
  .out_valid(out_valid)
);

// File: tb/dual_harmonic_lockin_tb.sv
module dual_harmonic_lockin_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 12;
  localparam int PW = 16;
  localparam int MAXLOG = 6;
  localparam int RLW = $clog2(MAXLOG + 1);
  localparam int OW = DW + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic signed [DW-1:0] sample_in = '0;
  logic [PW-1:0] freq_word = '0, phase_f = '0, phase_2f = '0;
  logic [RLW-1:0] rate_log2 = '0;
  logic signed [9:0] mod_out;
  logic signed [OW-1:0] i_f, q_f, i_2f, q_2f;
  logic out_valid;

  dual_harmonic_lockin #(.DW(DW), .PW(PW), .MAXLOG(MAXLOG)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_in(sample_in),
    .freq_word(freq_word), .phase_f(phase_f), .phase_2f(phase_2f),
    .rate_log2(rate_log2), .mod_out(mod_out), .i_f(i_f), .q_f(q_f),
    .i_2f(i_2f), .q_2f(q_2f), .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  longint pr [4][4096];
  longint h [256];
  longint held [4];
  int hlen;
  int keff;

  task automatic cmp(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint bsin(input int idx);
    real v;
    v = 511.0 * $sin(2.0 * 3.14159265358979 * idx / 64.0);
    if (v >= 0.0) return longint'($floor(v + 0.5));
    return -longint'($floor(-v + 0.5));
  endfunction

  function automatic int xgen(input int pat, input int n);
    case (pat)
      0: return 2047;
      1: return -2048;
      2: return ((n * 1103 + 12345) % 4096) - 2048;
      default: return (n % 2 == 0) ? 1500 : -1700;
    endcase
  endfunction

  function automatic longint expect_out(input int c, input int m);
    longint s = 0;
    for (int j = 0; j < hlen; j++)
      if (m - j >= 0) s += h[j] * pr[c][m - j];
    return s >>> (3 * keff);
  endfunction

  task automatic build_h(input int r);
    longint a [256];
    longint b [256];
    int len = 1;
    for (int i = 0; i < 256; i++) a[i] = 0;
    a[0] = 1;
    for (int st = 0; st < 3; st++) begin
      for (int i = 0; i < len + r - 1; i++) begin
        b[i] = 0;
        for (int j = 0; j < r; j++)
          if (i - j >= 0 && i - j < len) b[i] += a[i - j];
      end
      len = len + r - 1;
      for (int i = 0; i < len; i++) a[i] = b[i];
    end
    for (int i = 0; i < len; i++) h[i] = a[i];
    hlen = len;
  endtask

  task automatic run_case(input int fw, input int p1, input int p2, input int k,
                          input int pat, input int ns);
    int r;
    enable = 1'b0;
    freq_word = PW'(fw);
    phase_f = PW'(p1);
    phase_2f = PW'(p2);
    rate_log2 = RLW'(k);
    keff = (k > MAXLOG) ? MAXLOG : k;   // R6 clamp
    r = 1 << keff;
    build_h(r);
    for (int c = 0; c < 4; c++) held[c] = 0;
    @(negedge clk);
    for (int n = 0; n < ns; n++) begin
      int x, th, ph0, ph2;
      bit ev;
      x = xgen(pat, n);
      th = (n * fw) & 16'hFFFF;
      ph0 = (th + p1) & 16'hFFFF;
      ph2 = (2 * th + p2) & 16'hFFFF;
      pr[0][n] = x * bsin(ph0 >> 10);
      pr[1][n] = x * bsin(((ph0 + 16384) & 16'hFFFF) >> 10);
      pr[2][n] = x * bsin(ph2 >> 10);
      pr[3][n] = x * bsin(((ph2 + 16384) & 16'hFFFF) >> 10);
      sample_in = DW'(x);
      enable = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ev = ((n + 1) % r) == 0;
      cmp($sformatf("R5 valid cadence n=%0d", n), longint'(out_valid), longint'(ev));
      cmp($sformatf("R1 mod_out n=%0d", n), longint'(mod_out),
          bsin((((n + 1) * fw) & 16'hFFFF) >> 10));
      if (ev) for (int c = 0; c < 4; c++) held[c] = expect_out(c, n);
      cmp($sformatf("R2 R4 i_f n=%0d", n), longint'(i_f), held[0]);
      cmp($sformatf("R2 R4 q_f n=%0d", n), longint'(q_f), held[1]);
      cmp($sformatf("R3 R4 i_2f n=%0d", n), longint'(i_2f), held[2]);
      cmp($sformatf("R3 R4 q_2f n=%0d", n), longint'(q_2f), held[3]);
    end
    // R7: disable lands on an edge that would close a block
    sample_in = DW'(xgen(pat, ns));
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmp("R7 valid on disabled boundary", longint'(out_valid), 0);
    cmp("R7 mod_out cleared", longint'(mod_out), 0);
    cmp("R7 i_f cleared", longint'(i_f), 0);
    cmp("R7 q_f cleared", longint'(q_f), 0);
    cmp("R7 i_2f cleared", longint'(i_2f), 0);
    cmp("R7 q_2f cleared", longint'(q_2f), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R8 reset valid", longint'(out_valid), 0);
    cmp("R8 reset mod_out", longint'(mod_out), 0);
    cmp("R8 reset i_f", longint'(i_f), 0);
    cmp("R8 reset q_f", longint'(q_f), 0);
    cmp("R8 reset i_2f", longint'(i_2f), 0);
    cmp("R8 reset q_2f", longint'(q_2f), 0);
    run_case(1024, 0, 0, 2, 0, 255);
    run_case(3000, 12345, 40000, 0, 2, 200);
    run_case(777, 5000, 100, 3, 1, 511);
    run_case(65000, 65535, 32768, 6, 2, 1279);
    run_case(2048, 9000, 20000, 7, 3, 511);      // R6: code 7 acts as 6
    run_case(0, 16384, 0, 1, 0, 127);
    run_case(5461, 30000, 61000, 1, 3, 301);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule